// File: doc/BRIEF.md
# Multi-Digit Decimal Subtractor with Nines-Complement Arithmetic

This purely combinational block takes two unsigned packed-BCD numbers, a minuend and a subtrahend, each holding `NDIG` decimal digits (four by default). It returns the difference as a sign flag and a BCD magnitude. Every subtrahend digit is replaced by its nines complement. The complemented value is added to the minuend through a ripple of decimal digit adders, and each digit adder applies the +6 correction. A carry out of the top digit is then fed back into the lowest digit as an end-around carry, through a second ripple pass.

A carry out of the top digit means the difference is positive, and the corrected sum is already the answer. With no carry, the sum holds the negative result in nines-complement form. The block complements it again to give a plain BCD magnitude, and it raises the sign flag. Equal operands give all nines before this step. That case is reported as a positive zero.

The uncorrected end-around result is also available on its own output. A separate flag marks any input digit that is not a legal BCD code. The block has no registers: all outputs follow the inputs within the same evaluation.

Top module: `bcd_nines_subtractor`

## Requirements
- R1: When the minuend is greater than the subtrahend, `neg_o` is 0 and `mag_o` is the BCD encoding of minuend minus subtrahend.
- R2: When the minuend is less than the subtrahend, `neg_o` is 1 and `mag_o` is the BCD encoding of subtrahend minus minuend.
- R3: When both operands are equal, `mag_o` is zero and `neg_o` is 0. A negative zero of all nines never appears on `mag_o`.
- R4: `raw_o` holds the sum after the end-around carry. It equals the BCD difference when the result is positive. Otherwise it equals the BCD encoding of (10^NDIG - 1) minus the magnitude, so equal operands give all nines.
- R5: `bad_digit_o` is 1 exactly when any digit of either operand is in the range 1010 to 1111. When it is 1, the data outputs are unspecified.
- R6: With legal inputs, every digit of `mag_o` and `raw_o` is a legal BCD code (0000 to 1001).
- R7: A carry fed back into the lowest digit propagates through any run of nines. For example, 1000 minus 0000 gives 1000, and 1000 minus 0001 gives 0999.
- R8: Digit k of every operand and result occupies bits [4k+3:4k], and digit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| minuend_i | input | 4*NDIG | Packed-BCD minuend |
| subtrahend_i | input | 4*NDIG | Packed-BCD subtrahend |
| mag_o | output | 4*NDIG | Packed-BCD magnitude of the difference |
| neg_o | output | 1 | 1 when the difference is below zero |
| raw_o | output | 4*NDIG | Sum after the end-around carry, before the final re-complement |
| bad_digit_o | output | 1 | 1 when any input digit is outside 0 to 9 |

## Verification
The checker's result properties assume every operand digit is a legal BCD code. They apply only while the block's own input-validity flag is clear, and only the flag property is checked for illegal inputs. The bench sweeps every 8-bit pattern of both operands on a two-digit instance. This covers all 10,000 legal pairs with full result checks, and it checks only the flag on illegal patterns, as the requirement leaves the other outputs open. Random and directed operands on the four-digit instance are built digit by digit from the range 0 to 9, so that they stay legal.

// File: rtl/bcd_sub_pkg.sv
// Package: shared digit type and constants for the decimal subtractor.
// Assumes packed BCD with digit 0 in the least significant nibble.
package bcd_sub_pkg;
    typedef logic [3:0] bcd_digit_t;

    localparam bcd_digit_t DIGIT_MAX  = 4'd9;
    localparam bcd_digit_t NC_OFFSET  = 4'b1010;
    localparam bcd_digit_t DEC_ADJUST = 4'b0110;

    // True when a nibble is not a legal decimal digit
    function automatic logic digit_illegal(input bcd_digit_t d);
        return d > DIGIT_MAX;
    endfunction
endpackage

// File: rtl/bcd_nines_comp.sv
// Module: nines complement of one BCD digit.
// Forms the bitwise inverse plus 1010 and drops the carry out of the nibble.
// Assumes a legal digit; illegal codes give an unspecified result.
module bcd_nines_comp
    import bcd_sub_pkg::*;
(
    input  bcd_digit_t digit_i,
    output bcd_digit_t comp_o
);
    logic [4:0] widened;

    // Inverse plus offset, carry bit discarded
    always_comb begin
        widened = {1'b0, ~digit_i} + {1'b0, NC_OFFSET};
        comp_o  = widened[3:0];
    end
endmodule

// File: rtl/bcd_digit_add.sv
// Module: one decimal digit adder with +6 correction.
// Adds two digits and a carry in binary. It corrects when the nibble
// overflows or the sum exceeds nine, and the correction sets the decimal carry out.
// Assumes legal digits on both inputs.
module bcd_digit_add
    import bcd_sub_pkg::*;
(
    input  bcd_digit_t a_i,
    input  bcd_digit_t b_i,
    input  logic       c_i,
    output bcd_digit_t s_o,
    output logic       c_o
);
    logic [4:0] bin_sum;
    logic       fix;
    bcd_digit_t adjust;

    // Binary sum, correction decision and corrected digit
    always_comb begin
        bin_sum = {1'b0, a_i} + {1'b0, b_i} + {4'b0000, c_i};
        fix     = bin_sum[4] | (bin_sum[3:0] > DIGIT_MAX);
        adjust  = fix ? DEC_ADJUST : 4'd0;
        s_o     = bin_sum[3:0] + adjust;
        c_o     = fix;
    end
endmodule

// File: rtl/bcd_add_chain.sv
// Module: ripple chain of NDIG decimal digit adders.
// The decimal carry of each digit feeds the carry input of the next higher digit.
// Assumes legal BCD operands.
module bcd_add_chain
    import bcd_sub_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] a_i,
    input  logic [4*NDIG-1:0] b_i,
    input  logic              c_i,
    output logic [4*NDIG-1:0] s_o,
    output logic              c_o
);
    logic [NDIG:0] carry;

    assign carry[0] = c_i;
    assign c_o      = carry[NDIG];

    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        bcd_digit_add u_add (
            .a_i (a_i[4*k +: 4]),
            .b_i (b_i[4*k +: 4]),
            .c_i (carry[k]),
            .s_o (s_o[4*k +: 4]),
            .c_o (carry[k+1])
        );
    end
endmodule

// File: rtl/bcd_nines_subtractor.sv
// Module: multi-digit BCD subtractor (top).
// Computes minuend minus subtrahend as sign plus BCD magnitude. The steps are
// nines complement of the subtrahend, a decimal add, an end-around carry as a
// second ripple pass, and a re-complement when the result is negative.
// Purely combinational. Data outputs are unspecified when bad_digit_o is set.
module bcd_nines_subtractor
    import bcd_sub_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [4*NDIG-1:0] minuend_i,
    input  logic [4*NDIG-1:0] subtrahend_i,
    output logic [4*NDIG-1:0] mag_o,
    output logic              neg_o,
    output logic [4*NDIG-1:0] raw_o,
    output logic              bad_digit_o
);
    localparam int W = 4 * NDIG;

    logic [W-1:0]    sub_comp;
    logic [W-1:0]    first_sum;
    logic            end_carry;
    logic [W-1:0]    raw_comp;
    logic            eac_overflow;
    logic [NDIG-1:0] digit_is_nine;
    logic [NDIG-1:0] digit_bad;

    // Nines complement of the subtrahend, and of the raw result for negatives
    for (genvar k = 0; k < NDIG; k++) begin : g_comp
        bcd_nines_comp u_sub_nc (
            .digit_i (subtrahend_i[4*k +: 4]),
            .comp_o  (sub_comp[4*k +: 4])
        );
        bcd_nines_comp u_raw_nc (
            .digit_i (raw_o[4*k +: 4]),
            .comp_o  (raw_comp[4*k +: 4])
        );
        assign digit_is_nine[k] = (raw_o[4*k +: 4] == DIGIT_MAX);
        assign digit_bad[k]     = digit_illegal(minuend_i[4*k +: 4])
                                | digit_illegal(subtrahend_i[4*k +: 4]);
    end

    // First pass: minuend plus complemented subtrahend
    bcd_add_chain #(.NDIG(NDIG)) u_pass_add (
        .a_i (minuend_i),
        .b_i (sub_comp),
        .c_i (1'b0),
        .s_o (first_sum),
        .c_o (end_carry)
    );

    // Second pass: end-around carry rippled in from the lowest digit
    bcd_add_chain #(.NDIG(NDIG)) u_pass_eac (
        .a_i (first_sum),
        .b_i ({W{1'b0}}),
        .c_i (end_carry),
        .s_o (raw_o),
        .c_o (eac_overflow)
    );

    // Sign and magnitude selection; all nines without carry is a positive zero
    always_comb begin
        neg_o       = ~end_carry & ~(&digit_is_nine);
        mag_o       = end_carry ? raw_o : raw_comp;
        bad_digit_o = |digit_bad;
    end
endmodule

// File: rtl/bcd_sub_checker.sv
// Module: checker for the decimal subtractor, bound to the top module.
// The block has no clock, so the checks are immediate assertions on the
// settled port values. Result checks apply only while the inputs are legal.
module bcd_sub_checker #(
    parameter int NDIG = 4
) (
    input logic [4*NDIG-1:0] minuend_i,
    input logic [4*NDIG-1:0] subtrahend_i,
    input logic [4*NDIG-1:0] mag_o,
    input logic              neg_o,
    input logic [4*NDIG-1:0] raw_o,
    input logic              bad_digit_o,
    input logic              eac_overflow
);
    // Port-level consistency checks on every input change
    always_comb begin : chk
        logic any_bad;
        any_bad = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
            any_bad = any_bad | (minuend_i[4*k +: 4] > 4'd9)
                              | (subtrahend_i[4*k +: 4] > 4'd9);
        end
        a_r5_bad_flag: assert (bad_digit_o == any_bad)
            else $error("a_r5_bad_flag");
        if (!any_bad) begin
            for (int k = 0; k < NDIG; k++) begin
                a_r6_digits_legal: assert ((mag_o[4*k +: 4] <= 4'd9) && (raw_o[4*k +: 4] <= 4'd9))
                    else $error("a_r6_digits_legal");
                if (neg_o) begin
                    a_r2_neg_pairs_nine: assert (({1'b0, mag_o[4*k +: 4]} + {1'b0, raw_o[4*k +: 4]}) == 5'd9)
                        else $error("a_r2_neg_pairs_nine");
                end
            end
            if (!neg_o && (mag_o != '0)) begin
                a_r1_pos_raw_is_mag: assert (raw_o == mag_o)
                    else $error("a_r1_pos_raw_is_mag");
            end
            if (minuend_i == subtrahend_i) begin
                a_r3_equal_zero: assert ((mag_o == '0) && !neg_o)
                    else $error("a_r3_equal_zero");
            end
            a_r7_single_eac: assert (!eac_overflow)
                else $error("a_r7_single_eac");
        end
    end
endmodule

bind bcd_nines_subtractor bcd_sub_checker #(.NDIG(NDIG)) u_chk (
    .minuend_i    (minuend_i),
    .subtrahend_i (subtrahend_i),
    .mag_o        (mag_o),
    .neg_o        (neg_o),
    .raw_o        (raw_o),
    .bad_digit_o  (bad_digit_o),
    .eac_overflow (eac_overflow)
);

// File: tb/bcd_nines_subtractor_tb.sv
// Bench: an exhaustive two-digit sweep, and random plus directed four-digit vectors.
// Expected values come from integer subtraction of the decoded operands.
module bcd_nines_subtractor_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    logic [15:0] m4, s4, mag4, raw4;
    logic        neg4, bad4;
    logic [7:0]  m2, s2, mag2, raw2;
    logic        neg2, bad2;

    bcd_nines_subtractor #(.NDIG(4)) u_dut (
        .minuend_i (m4), .subtrahend_i (s4), .mag_o (mag4),
        .neg_o (neg4), .raw_o (raw4), .bad_digit_o (bad4)
    );
    bcd_nines_subtractor #(.NDIG(2)) u_dut2 (
        .minuend_i (m2), .subtrahend_i (s2), .mag_o (mag2),
        .neg_o (neg2), .raw_o (raw2), .bad_digit_o (bad2)
    );

    // Encode a non-negative integer as four BCD digits, digit 0 lowest (R8)
    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int k = 0; k < 4; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Decode packed BCD; returns -1 if any digit is illegal
    function automatic int from_bcd(input logic [15:0] b, input int nd);
        int v;
        v = 0;
        for (int k = nd - 1; k >= 0; k--) begin
            if (b[4*k +: 4] > 4'd9) return -1;
            v = v * 10 + int'(b[4*k +: 4]);
        end
        return v;
    endfunction

    task automatic expect_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Full result check for nd digits against integer arithmetic
    task automatic check_result(input int nd, input logic [15:0] mi, input logic [15:0] si,
                                input logic [15:0] mag, input logic neg,
                                input logic [15:0] raw, input logic bad);
        int mv, sv, diff, top;
        logic [15:0] mask;
        mv   = from_bcd(mi, nd);
        sv   = from_bcd(si, nd);
        mask = (nd == 4) ? 16'hFFFF : 16'h00FF;
        top  = (nd == 4) ? 9999 : 99;
        if (mv < 0 || sv < 0) begin
            expect_eq("R5 bad flag on illegal digit", {15'd0, bad}, 16'd1);
        end else begin
            diff = mv - sv;
            expect_eq("R5 bad flag clear", {15'd0, bad}, 16'd0);
            if (diff > 0) begin
                expect_eq("R1 positive magnitude", mag, to_bcd(diff) & mask);
                expect_eq("R1 positive sign", {15'd0, neg}, 16'd0);
                expect_eq("R4 raw positive", raw, to_bcd(diff) & mask);
            end else if (diff < 0) begin
                expect_eq("R2 negative magnitude", mag, to_bcd(-diff) & mask);
                expect_eq("R2 negative sign", {15'd0, neg}, 16'd1);
                expect_eq("R4 raw nines form", raw, to_bcd(top + diff) & mask);
            end else begin
                expect_eq("R3 equal magnitude", mag, 16'd0);
                expect_eq("R3 equal sign", {15'd0, neg}, 16'd0);
                expect_eq("R4 raw all nines", raw, to_bcd(top) & mask);
            end
            for (int k = 0; k < nd; k++) begin
                checks++;
                if (mag[4*k +: 4] > 4'd9) begin
                    failures++;
                    $display("FAIL R6 digit %0d actual=%h expected<=9", k, mag[4*k +: 4]);
                end
            end
        end
    endtask

    task automatic run4(input int mv, input int sv);
        @(posedge clk);
        m4 = to_bcd(mv);
        s4 = to_bcd(sv);
        @(negedge clk);
        check_result(4, m4, s4, mag4, neg4, raw4, bad4);
    endtask

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m4 = '0; s4 = '0; m2 = '0; s2 = '0;
        @(negedge clk);
        // Zero inputs: positive zero, nothing flagged (R3)
        expect_eq("R3 idle magnitude", mag4, 16'd0);
        expect_eq("R3 idle sign", {15'd0, neg4}, 16'd0);

        // End-around carry through runs of nines (R7)
        run4(1000, 0);
        expect_eq("R7 1000-0000", mag4, 16'h1000);
        run4(1000, 1);
        expect_eq("R7 1000-0001", mag4, 16'h0999);
        run4(9999, 0);
        run4(0, 9999);
        expect_eq("R2 0000-9999", mag4, 16'h9999);
        run4(5000, 5000);
        run4(1, 0);
        run4(0, 1);

        // Exhaustive two-digit sweep over all byte patterns (R1-R6)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                @(posedge clk);
                m2 = 8'(a);
                s2 = 8'(b);
                @(negedge clk);
                check_result(2, {8'd0, m2}, {8'd0, s2}, {8'd0, mag2}, neg2, {8'd0, raw2}, bad2);
            end
        end

        // Illegal digit in the top position of a four-digit operand (R5)
        @(posedge clk);
        m4 = 16'hA000;
        s4 = 16'h0000;
        @(negedge clk);
        expect_eq("R5 illegal top digit", {15'd0, bad4}, 16'd1);

        // Random legal four-digit vectors
        for (int i = 0; i < 4000; i++) begin
            run4(int'($urandom % 10000), int'($urandom % 10000));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule